// File: doc/BRIEF.md
# DDR SDRAM Command Bus Monitor

This block watches the command bus of a four-bank double-data-rate SDRAM and decodes what the controller issues on each rising clock edge. It samples the clock enable, the active-low select, row strobe, column strobe and write enable, the two bank-select bits and the multiplexed address bus. From these it produces a command code and keeps a per-bank model of which banks have an open row and which row that is.

Alongside the decode, the monitor enforces bank-state legality and the inter-command spacing rules: activate to column access, precharge to activate, activate to activate across banks, minimum and maximum row-open time, row cycle time, mode-register-set recovery, and the hidden precharge that follows a read or write with auto precharge. All nanosecond limits are parameters that are converted to clock counts, rounded up, so the same RTL serves any clock rate. Violations are recorded as sticky flags together with a code and the bank involved, and stay set until reset. The block is placed next to a memory controller in simulation or in silicon as a protocol checker; it drives nothing on the memory bus.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: When the select input is sampled high (with the clock enable high in this and the previous cycle) the command is masked: the command code is 0 and no bank state, counter or flag changes because of it.
- R2: The command code appears on `cmdCode` in the cycle after the sampling edge, with pins {rowStrobeN, colStrobeN, writeEnN}: 000 mode set (bank 00 gives 1, bank 01 gives 2), 001 refresh 10, 010 precharge 8 (address bit 10 high: precharge-all 9), 011 activate 3, 100 write 6 (bit 10 high: 7), 101 read 4 (bit 10 high: 5), 110 burst stop 12, 111 no operation 0; clock enable falling with the refresh pattern gives 11, otherwise 13; no decode while the previous clock enable was low.
- R3: A legal activate opens bank `ba` (00..11 map to banks 0..3, `bankOpen` bit = bank) and stores the full address bus as its row in `openRows[bank*ROW_W +: ROW_W]`.
- R4: A precharge with address bit 10 low closes only bank `ba`; with bit 10 high it closes every open bank and `ba` is ignored.
- R5: A read or write to a closed bank, an activate to an open bank, or a mode set, refresh or self-refresh entry while any bank is open sets flag bit 0 (bank: the addressed one, or the lowest open bank for the all-bank commands) and changes no bank state nor the burst setting.
- R6: A read or write issued fewer than the activate-to-column count of cycles after that bank's activate sets flag bit 1.
- R7: An activate issued fewer than the precharge count of cycles after that bank was closed (explicitly or by auto precharge) sets flag bit 2.
- R8: An activate issued fewer than the activate-to-activate count of cycles after any previous activate sets flag bit 3.
- R9: A precharge of a bank open fewer than the minimum row-open count, or a bank staying open for exactly the maximum row-open count of cycles, sets flag bit 4.
- R10: An activate issued fewer than the row cycle count after the previous activate of the same bank sets flag bit 5.
- R11: Any command other than no operation and power-down issued fewer than the mode-set recovery count of cycles after a mode or extended mode set sets flag bit 6.
- R12: A read with auto precharge closes its bank burst/2 cycles after the command, a write with auto precharge burst/2 plus write recovery cycles after; a read or write to that bank in between sets flag bit 7 and is otherwise ignored.
- R13: The burst length is taken from address bits 2:0 of a mode set to bank 00 (001 = 2, 010 = 4, 011 = 8, others keep the old value); it is 2 after reset and an extended mode set (bank 01) leaves it unchanged.
- R14: Flags in `violSticky` only accumulate until reset; `violCode` holds 1 plus the lowest flag index raised in the latest cycle that raised any, `violBank` its bank, and both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock, rising edge samples |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | ROW_W | Multiplexed row/column/opcode address, bit 10 selects auto/all precharge |
| cmdCode | output | 4 | Decoded command of the previous edge |
| bankOpen | output | 4 | One bit per bank, 1 = row open |
| openRows | output | 4*ROW_W | Open row per bank, bank 0 in the low bits |
| violSticky | output | 8 | Sticky violation flags |
| violCode | output | 4 | Latest violation code, 0 = none |
| violBank | output | 2 | Bank of the latest violation |

## Verification
The bench builds the monitor with a 10 ns clock period and a maximum row-open time of 200 ns, leaving the other limits at their defaults; this turns them into 2 cycles for activate-to-column, precharge and activate-to-activate, 7 for the row cycle, 5 for the minimum and 20 for the maximum row-open time. With counts this small every limit can be hit exactly on and one cycle short of its bound, including the expiry of the maximum open time, within short directed sequences. Auto-precharge closure is timed with burst lengths 2, 4 and 8 so the hidden precharge point and the precharge time counted from it are both observed at the ports.

// File: rtl/ddr_mon_pkg.sv
`timescale 1ns/1ps
package ddr_mon_pkg;

  localparam int NBANK  = 4;
  localparam int BANK_W = 2;
  localparam int NVIOL  = 8;
  localparam int AP_W   = 8;

  // flag indices; lower index wins when several rise together
  localparam int V_STATE  = 0;
  localparam int V_RCD    = 1;
  localparam int V_RP     = 2;
  localparam int V_RRD    = 3;
  localparam int V_RAS    = 4;
  localparam int V_RC     = 5;
  localparam int V_MRD    = 6;
  localparam int V_APBUSY = 7;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_MRS  = 4'd1,
    CMD_EMRS = 4'd2,
    CMD_ACT  = 4'd3,
    CMD_RD   = 4'd4,
    CMD_RDA  = 4'd5,
    CMD_WR   = 4'd6,
    CMD_WRA  = 4'd7,
    CMD_PRE  = 4'd8,
    CMD_PREA = 4'd9,
    CMD_REF  = 4'd10,
    CMD_SREF = 4'd11,
    CMD_BST  = 4'd12,
    CMD_PDN  = 4'd13
  } cmd_e;

  // control -> per-bank datapath strobes
  typedef struct packed {
    logic [NBANK-1:0] act;
    logic [NBANK-1:0] pre;
    logic [NBANK-1:0] apStart;
    logic [AP_W-1:0]  apLen;
  } bank_strobe_t;

endpackage

// File: rtl/ddr_mon_bank.sv
`timescale 1ns/1ps
module ddr_mon_bank
  import ddr_mon_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             doAct,
  input  logic             doPre,
  input  logic             doAp,
  input  logic [AP_W-1:0]  apLen,
  input  logic [ROW_W-1:0] rowIn,
  output logic             isOpen,
  output logic [ROW_W-1:0] rowQ,
  output logic [CNT_W-1:0] sinceAct,
  output logic [CNT_W-1:0] sincePre,
  output logic             apBusy
);

  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic [AP_W-1:0] apCnt;
  logic            apDone;

  assign apDone = (apCnt == AP_W'(1));
  assign apBusy = (apCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isOpen   <= 1'b0;
      rowQ     <= '0;
      sinceAct <= CNT_SAT;
      sincePre <= CNT_SAT;
      apCnt    <= '0;
    end else begin
      if (doAct)                  sinceAct <= CNT_W'(1);
      else if (sinceAct != CNT_SAT) sinceAct <= sinceAct + 1'b1;

      if (doPre || apDone)        sincePre <= CNT_W'(1);
      else if (sincePre != CNT_SAT) sincePre <= sincePre + 1'b1;

      if (doAct) begin
        isOpen <= 1'b1;
        rowQ   <= rowIn;
        apCnt  <= '0;
      end else if (doPre || apDone) begin
        isOpen <= 1'b0;
        apCnt  <= '0;
      end else if (doAp) begin
        apCnt  <= apLen;
      end else if (apBusy) begin
        apCnt  <= apCnt - 1'b1;
      end
    end
  end

  assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !doAct |=> $stable(rowQ));

  assert_ap_close_R12: assert property (@(posedge clk) disable iff (!rstN)
    (apDone && !doAct) |=> !isOpen);

  assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rstN)
    doAct |=> (isOpen && !apBusy));

endmodule

// File: rtl/ddr_mon_ctrl.sv
`timescale 1ns/1ps
module ddr_mon_ctrl
  import ddr_mon_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int RCD_C    = 3,
  parameter int RP_C     = 3,
  parameter int RRD_C    = 2,
  parameter int RC_C     = 9,
  parameter int RASMIN_C = 6,
  parameter int RASMAX_C = 100,
  parameter int MRD_C    = 2,
  parameter int WR_C     = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cke,
  input  logic                        csN,
  input  logic                        rasN,
  input  logic                        casN,
  input  logic                        weN,
  input  logic [BANK_W-1:0]           ba,
  input  logic                        addrAp,
  input  logic [2:0]                  addrLow,
  input  logic [NBANK-1:0]            bankOpen,
  input  logic [NBANK-1:0]            bankApBusy,
  input  logic [NBANK-1:0][CNT_W-1:0] sinceAct,
  input  logic [NBANK-1:0][CNT_W-1:0] sincePre,
  output bank_strobe_t                strobe,
  output logic [3:0]                  cmdCode,
  output logic [NVIOL-1:0]            violSticky,
  output logic [3:0]                  violCode,
  output logic [BANK_W-1:0]           violBank
);

  localparam logic [CNT_W-1:0] CNT_SAT    = '1;
  localparam logic [CNT_W-1:0] RCD_V      = CNT_W'(RCD_C);
  localparam logic [CNT_W-1:0] RP_V       = CNT_W'(RP_C);
  localparam logic [CNT_W-1:0] RRD_V      = CNT_W'(RRD_C);
  localparam logic [CNT_W-1:0] RC_V       = CNT_W'(RC_C);
  localparam logic [CNT_W-1:0] RASMIN_V   = CNT_W'(RASMIN_C);
  localparam logic [CNT_W-1:0] RASMAX_V   = CNT_W'(RASMAX_C);
  localparam logic [CNT_W-1:0] MRD_V      = CNT_W'(MRD_C);
  localparam logic [AP_W-1:0]  WR_V       = AP_W'(WR_C);

  cmd_e                    cmdNow;
  cmd_e                    cmdQ;
  logic                    ckePrev;
  logic [AP_W-1:0]         blHalf;
  logic [CNT_W-1:0]        sinceAnyAct;
  logic [CNT_W-1:0]        sinceMrs;
  logic                    anyOpen;
  logic [BANK_W-1:0]       lowestOpen;
  logic [NVIOL-1:0]        newV;
  logic [NVIOL-1:0][BANK_W-1:0] vBank;
  logic                    blLoad;
  logic [3:0]              pickCode;
  logic [BANK_W-1:0]       pickBank;

  // ---------------- command decode ----------------
  always_comb begin
    cmdNow = CMD_NOP;
    if (ckePrev) begin
      if (!cke) begin
        if (!csN && !rasN && !casN && weN) cmdNow = CMD_SREF;
        else                               cmdNow = CMD_PDN;
      end else if (!csN) begin
        unique case ({rasN, casN, weN})
          3'b000: begin
            if (ba == 2'b00)      cmdNow = CMD_MRS;
            else if (ba == 2'b01) cmdNow = CMD_EMRS;
            else                  cmdNow = CMD_NOP;
          end
          3'b001: cmdNow = CMD_REF;
          3'b010: cmdNow = addrAp ? CMD_PREA : CMD_PRE;
          3'b011: cmdNow = CMD_ACT;
          3'b100: cmdNow = addrAp ? CMD_WRA : CMD_WR;
          3'b101: cmdNow = addrAp ? CMD_RDA : CMD_RD;
          3'b110: cmdNow = CMD_BST;
          default: cmdNow = CMD_NOP;
        endcase
      end
    end
  end

  // ---------------- legality and timing ----------------
  always_comb begin
    anyOpen    = |bankOpen;
    lowestOpen = '0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (bankOpen[b]) lowestOpen = BANK_W'(b);
    end
  end

  always_comb begin
    strobe = '0;
    newV   = '0;
    blLoad = 1'b0;
    for (int i = 0; i < NVIOL; i++) vBank[i] = ba;

    // maximum open time reached; a command-driven row-time flag overrides the bank below
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (bankOpen[b] && (sinceAct[b] == RASMAX_V)) begin
        newV[V_RAS]  = 1'b1;
        vBank[V_RAS] = BANK_W'(b);
      end
    end

    unique case (cmdNow)
      CMD_MRS, CMD_EMRS, CMD_REF, CMD_SREF: begin
        if (anyOpen) begin
          newV[V_STATE]  = 1'b1;
          vBank[V_STATE] = lowestOpen;
        end else if (cmdNow == CMD_MRS) begin
          blLoad = 1'b1;
        end
      end
      CMD_ACT: begin
        if (bankOpen[ba]) begin
          newV[V_STATE] = 1'b1;
        end else begin
          strobe.act[ba] = 1'b1;
          if (sincePre[ba] < RP_V)  newV[V_RP]  = 1'b1;
          if (sinceAct[ba] < RC_V)  newV[V_RC]  = 1'b1;
          if (sinceAnyAct < RRD_V)  newV[V_RRD] = 1'b1;
        end
      end
      CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
        if (!bankOpen[ba]) begin
          newV[V_STATE] = 1'b1;
        end else if (bankApBusy[ba]) begin
          newV[V_APBUSY] = 1'b1;
        end else begin
          if (sinceAct[ba] < RCD_V) newV[V_RCD] = 1'b1;
          if (cmdNow == CMD_RDA) begin
            strobe.apStart[ba] = 1'b1;
            strobe.apLen       = blHalf;
          end else if (cmdNow == CMD_WRA) begin
            strobe.apStart[ba] = 1'b1;
            strobe.apLen       = blHalf + WR_V;
          end
        end
      end
      CMD_PRE: begin
        if (bankOpen[ba]) begin
          strobe.pre[ba] = 1'b1;
          if (sinceAct[ba] < RASMIN_V) begin
            newV[V_RAS]  = 1'b1;
            vBank[V_RAS] = ba;
          end
        end
      end
      CMD_PREA: begin
        for (int b = NBANK - 1; b >= 0; b--) begin
          if (bankOpen[b]) begin
            strobe.pre[b] = 1'b1;
            if (sinceAct[b] < RASMIN_V) begin
              newV[V_RAS]  = 1'b1;
              vBank[V_RAS] = BANK_W'(b);
            end
          end
        end
      end
      default: ;
    endcase

    if ((cmdNow != CMD_NOP) && (cmdNow != CMD_PDN) && (sinceMrs < MRD_V))
      newV[V_MRD] = 1'b1;
  end

  always_comb begin
    pickCode = 4'd0;
    pickBank = '0;
    for (int i = NVIOL - 1; i >= 0; i--) begin
      if (newV[i]) begin
        pickCode = 4'(i + 1);
        pickBank = vBank[i];
      end
    end
  end

  // ---------------- state ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckePrev     <= 1'b1;
      cmdQ        <= CMD_NOP;
      blHalf      <= AP_W'(1);
      sinceAnyAct <= CNT_SAT;
      sinceMrs    <= CNT_SAT;
      violSticky  <= '0;
      violCode    <= '0;
      violBank    <= '0;
    end else begin
      ckePrev <= cke;
      cmdQ    <= cmdNow;

      if (blLoad) begin
        unique case (addrLow)
          3'b001:  blHalf <= AP_W'(1);
          3'b010:  blHalf <= AP_W'(2);
          3'b011:  blHalf <= AP_W'(4);
          default: blHalf <= blHalf;
        endcase
      end

      if (|strobe.act)               sinceAnyAct <= CNT_W'(1);
      else if (sinceAnyAct != CNT_SAT) sinceAnyAct <= sinceAnyAct + 1'b1;

      if ((cmdNow == CMD_MRS) || (cmdNow == CMD_EMRS)) sinceMrs <= CNT_W'(1);
      else if (sinceMrs != CNT_SAT)                    sinceMrs <= sinceMrs + 1'b1;

      violSticky <= violSticky | newV;
      if (|newV) begin
        violCode <= pickCode;
        violBank <= pickBank;
      end
    end
  end

  assign cmdCode = cmdQ;

  // ---------------- assertions ----------------
  assert_cs_mask_R1: assert property (@(posedge clk) disable iff (!rstN)
    (csN && cke && ckePrev) |=> (cmdCode == 4'd0));

  assert_sticky_R14: assert property (@(posedge clk) disable iff (!rstN)
    (violSticky != '0) |=> ((violSticky & $past(violSticky)) == $past(violSticky)));

  assert_code_flags_R14: assert property (@(posedge clk) disable iff (!rstN)
    (violCode != 4'd0) == (violSticky != '0));

  assert_one_act_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.act));

  assert_mrd_gap_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((MRD_C >= 2) && ((cmdNow == CMD_MRS) || (cmdNow == CMD_EMRS)))
    |=> ((cmdNow == CMD_NOP) || (cmdNow == CMD_PDN) || newV[V_MRD]));

  assert_no_ap_overlap_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.apStart & bankApBusy) == '0));

endmodule

// File: rtl/ddr_cmd_monitor.sv
`timescale 1ns/1ps
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int ROW_W         = 13,
  parameter int CLK_PERIOD_PS = 7500,
  parameter int T_RCD_PS      = 20000,
  parameter int T_RP_PS       = 20000,
  parameter int T_RRD_PS      = 15000,
  parameter int T_RC_PS       = 65000,
  parameter int T_RAS_MIN_PS  = 45000,
  parameter int T_RAS_MAX_PS  = 120000000,
  parameter int T_MRD_CYC     = 2,
  parameter int T_WR_CYC      = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cke,
  input  logic                   csN,
  input  logic                   rasN,
  input  logic                   casN,
  input  logic                   weN,
  input  logic [1:0]             ba,
  input  logic [ROW_W-1:0]       addr,
  output logic [3:0]             cmdCode,
  output logic [3:0]             bankOpen,
  output logic [4*ROW_W-1:0]     openRows,
  output logic [7:0]             violSticky,
  output logic [3:0]             violCode,
  output logic [1:0]             violBank
);

  localparam int RCD_C    = (T_RCD_PS     + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int RP_C     = (T_RP_PS      + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int RRD_C    = (T_RRD_PS     + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int RC_C     = (T_RC_PS      + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int RASMIN_C = (T_RAS_MIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int RASMAX_C = (T_RAS_MAX_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int TOP_A    = (RASMAX_C > RC_C) ? RASMAX_C : RC_C;
  localparam int CNT_TOP  = (TOP_A > T_MRD_CYC) ? TOP_A : T_MRD_CYC;
  localparam int CNT_W    = $clog2(CNT_TOP + 2);

  bank_strobe_t                strobe;
  logic [NBANK-1:0]            openVec;
  logic [NBANK-1:0]            apBusyVec;
  logic [NBANK-1:0][CNT_W-1:0] sinceActVec;
  logic [NBANK-1:0][CNT_W-1:0] sincePreVec;

  ddr_mon_ctrl #(
    .CNT_W(CNT_W), .RCD_C(RCD_C), .RP_C(RP_C), .RRD_C(RRD_C), .RC_C(RC_C),
    .RASMIN_C(RASMIN_C), .RASMAX_C(RASMAX_C), .MRD_C(T_MRD_CYC), .WR_C(T_WR_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addrAp(addr[10]), .addrLow(addr[2:0]),
    .bankOpen(openVec), .bankApBusy(apBusyVec),
    .sinceAct(sinceActVec), .sincePre(sincePreVec),
    .strobe(strobe), .cmdCode(cmdCode), .violSticky(violSticky),
    .violCode(violCode), .violBank(violBank)
  );

  for (genvar b = 0; b < NBANK; b++) begin : gBank
    ddr_mon_bank #(.ROW_W(ROW_W), .CNT_W(CNT_W)) uBank (
      .clk(clk), .rstN(rstN),
      .doAct(strobe.act[b]), .doPre(strobe.pre[b]), .doAp(strobe.apStart[b]),
      .apLen(strobe.apLen), .rowIn(addr),
      .isOpen(openVec[b]), .rowQ(openRows[b*ROW_W +: ROW_W]),
      .sinceAct(sinceActVec[b]), .sincePre(sincePreVec[b]),
      .apBusy(apBusyVec[b])
    );
  end

  assign bankOpen = openVec;

  assert_prea_closes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cke && !csN && !rasN && casN && !weN && addr[10]) |=> (bankOpen == 4'b0000));

endmodule

// File: tb/tb_ddr_cmd_monitor.sv
`timescale 1ns/1ps
module tb_ddr_cmd_monitor;

  localparam int ROW_W = 13;
  localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_PRE = 3'b010,
                         P_ACT = 3'b011, P_WR  = 3'b100, P_RD  = 3'b101,
                         P_BST = 3'b110, P_NOP = 3'b111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] ba = '0;
  logic [ROW_W-1:0] addr = '0;
  logic [3:0] cmdCode, bankOpen, violCode;
  logic [4*ROW_W-1:0] openRows;
  logic [7:0] violSticky;
  logic [1:0] violBank;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  ddr_cmd_monitor #(
    .ROW_W(ROW_W), .CLK_PERIOD_PS(10000), .T_RAS_MAX_PS(200000)
  ) dut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .cmdCode(cmdCode), .bankOpen(bankOpen),
    .openRows(openRows), .violSticky(violSticky), .violCode(violCode),
    .violBank(violBank)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cke = 1'b1; csN = 1'b1; {rasN, casN, weN} = P_NOP;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // one command at the next rising edge; sample 1 ns after it
  task automatic cmd(input logic [2:0] pins, input logic [1:0] b, input logic [ROW_W-1:0] a);
    @(negedge clk);
    csN = 1'b0; {rasN, casN, weN} = pins; ba = b; addr = a;
    @(posedge clk); #1;
  endtask

  task automatic masked(input logic [2:0] pins, input logic [1:0] b, input logic [ROW_W-1:0] a);
    @(negedge clk);
    csN = 1'b1; {rasN, casN, weN} = pins; ba = b; addr = a;
    @(posedge clk); #1;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      csN = 1'b1; {rasN, casN, weN} = P_NOP;
      @(posedge clk); #1;
    end
  endtask

  task automatic tReset();
    doReset();
    @(posedge clk); #1;
    chk("R14 reset flags", violSticky, 0);
    chk("R14 reset code", violCode, 0);
    chk("R2 reset cmd", cmdCode, 0);
    chk("R3 reset banks", bankOpen, 0);
  endtask

  task automatic tDecode();
    doReset();
    cmd(P_MRS, 2'b00, 13'h002); chk("R2 MRS code", cmdCode, 1);
    nop(1);
    cmd(P_MRS, 2'b01, 13'h000); chk("R2 EMRS code", cmdCode, 2);
    nop(1);
    cmd(P_REF, 2'b00, 13'h000); chk("R2 REF code", cmdCode, 10);
    cmd(P_BST, 2'b00, 13'h000); chk("R2 BST code", cmdCode, 12);
    masked(P_ACT, 2'b10, 13'h0055);
    chk("R1 masked code", cmdCode, 0);
    chk("R1 masked no open", bankOpen, 0);
    cmd(P_NOP, 2'b00, 13'h000); chk("R2 NOP code", cmdCode, 0);
    chk("R1 no flags", violSticky, 0);
  endtask

  task automatic tActPre();
    doReset();
    cmd(P_ACT, 2'b10, 13'h1ABC);
    chk("R2 ACT code", cmdCode, 3);
    chk("R3 open bank2", bankOpen, 4'b0100);
    chk("R3 row bank2", openRows[2*ROW_W +: ROW_W], 13'h1ABC);
    nop(1);
    cmd(P_ACT, 2'b01, 13'h0123);
    chk("R3 open bank1", bankOpen, 4'b0110);
    chk("R3 row bank1", openRows[1*ROW_W +: ROW_W], 13'h0123);
    nop(5);
    cmd(P_PRE, 2'b01, 13'h0000);
    chk("R2 PRE code", cmdCode, 8);
    chk("R4 single close", bankOpen, 4'b0100);
    nop(1);
    cmd(P_PRE, 2'b01, 13'h0400);
    chk("R2 PREA code", cmdCode, 9);
    chk("R4 all close", bankOpen, 4'b0000);
    chk("R4 legal flow", violSticky, 0);
  endtask

  task automatic tIllegal();
    doReset();
    cmd(P_RD, 2'b11, 13'h0010);
    chk("R5 rd closed flag", violSticky, 8'h01);
    chk("R5 rd closed code", violCode, 1);
    chk("R5 rd closed bank", violBank, 3);
    doReset();
    cmd(P_ACT, 2'b00, 13'h0005);
    nop(6);
    cmd(P_ACT, 2'b00, 13'h0009);
    chk("R5 act open flag", violSticky, 8'h01);
    chk("R5 row kept", openRows[0 +: ROW_W], 13'h0005);
    doReset();
    cmd(P_ACT, 2'b01, 13'h0007);
    nop(6);
    cmd(P_MRS, 2'b00, 13'h0003);
    chk("R5 mrs open flag", violSticky, 8'h01);
    chk("R5 mrs open bank", violBank, 1);
  endtask

  task automatic tRcd();
    doReset();
    cmd(P_ACT, 2'b00, 13'h0001);
    cmd(P_RD, 2'b00, 13'h0000);
    chk("R6 rcd flag", violSticky, 8'h02);
    chk("R6 rcd code", violCode, 2);
    doReset();
    cmd(P_ACT, 2'b00, 13'h0001);
    nop(1);
    cmd(P_RD, 2'b00, 13'h0000);
    chk("R6 rcd ok", violSticky, 0);
    chk("R2 RD code", cmdCode, 4);
  endtask

  task automatic tRpRc();
    doReset();
    cmd(P_ACT, 2'b00, 13'h0001);
    nop(5);
    cmd(P_PRE, 2'b00, 13'h0000);
    cmd(P_ACT, 2'b00, 13'h0002);
    chk("R7 rp flag", violSticky, 8'h04);
    chk("R7 rp code", violCode, 3);
    doReset();
    cmd(P_ACT, 2'b00, 13'h0001);
    nop(4);
    cmd(P_PRE, 2'b00, 13'h0000);
    nop(1);
    cmd(P_ACT, 2'b00, 13'h0002);
    chk("R10 rc bound ok", violSticky, 0);
    doReset();
    cmd(P_ACT, 2'b00, 13'h0001);
    nop(4);
    cmd(P_PRE, 2'b00, 13'h0000);
    cmd(P_ACT, 2'b00, 13'h0002);
    chk("R10 rc flag", violSticky, 8'h24);
  endtask

  task automatic tRrd();
    doReset();
    cmd(P_ACT, 2'b00, 13'h0001);
    cmd(P_ACT, 2'b01, 13'h0002);
    chk("R8 rrd flag", violSticky, 8'h08);
    chk("R8 rrd bank", violBank, 1);
    chk("R8 act applied", bankOpen, 4'b0011);
  endtask

  task automatic tRas();
    doReset();
    cmd(P_ACT, 2'b10, 13'h0001);
    nop(2);
    cmd(P_PRE, 2'b10, 13'h0000);
    chk("R9 ras min flag", violSticky, 8'h10);
    chk("R9 ras min code", violCode, 5);
    chk("R9 pre applied", bankOpen, 0);
    doReset();
    cmd(P_ACT, 2'b11, 13'h0001);
    nop(19);
    chk("R9 ras max before", violSticky, 0);
    nop(1);
    chk("R9 ras max flag", violSticky, 8'h10);
    chk("R9 ras max bank", violBank, 3);
  endtask

  task automatic tMrd();
    doReset();
    cmd(P_MRS, 2'b00, 13'h0002);
    cmd(P_ACT, 2'b00, 13'h0001);
    chk("R11 mrd flag", violSticky, 8'h40);
    chk("R11 mrd code", violCode, 7);
  endtask

  task automatic tAutoPre();
    doReset();
    cmd(P_MRS, 2'b00, 13'h0002);          // burst 4
    nop(1);
    cmd(P_ACT, 2'b01, 13'h0011);
    nop(1);
    cmd(P_RD, 2'b01, 13'h0400);
    chk("R2 RDA code", cmdCode, 5);
    nop(1);
    chk("R12 rda still open", bankOpen, 4'b0010);
    nop(1);
    chk("R12 rda closed", bankOpen, 4'b0000);
    cmd(P_ACT, 2'b01, 13'h0012);
    chk("R12 rp after ap", violSticky, 8'h24);
    chk("R12 rp after ap code", violCode, 3);

    doReset();
    cmd(P_MRS, 2'b00, 13'h0003);          // burst 8
    nop(1);
    cmd(P_ACT, 2'b00, 13'h0021);
    nop(1);
    cmd(P_WR, 2'b00, 13'h0400);
    chk("R2 WRA code", cmdCode, 7);
    cmd(P_RD, 2'b00, 13'h0000);
    chk("R12 ap busy flag", violSticky, 8'h80);
    chk("R12 ap busy code", violCode, 8);
    nop(4);
    chk("R12 wra still open", bankOpen, 4'b0001);
    nop(1);
    chk("R12 wra closed", bankOpen, 4'b0000);
  endtask

  task automatic tEmrs();
    doReset();
    cmd(P_MRS, 2'b01, 13'h0003);          // extended set, must not touch burst
    nop(1);
    cmd(P_ACT, 2'b11, 13'h0031);
    nop(1);
    cmd(P_RD, 2'b11, 13'h0400);
    chk("R13 open at rda", bankOpen, 4'b1000);
    nop(1);
    chk("R13 burst2 close", bankOpen, 4'b0000);
    chk("R13 no flags", violSticky, 0);
  endtask

  task automatic tSticky();
    doReset();
    cmd(P_ACT, 2'b00, 13'h0001);
    cmd(P_RD, 2'b00, 13'h0000);
    nop(3);
    chk("R14 held", violSticky, 8'h02);
    cmd(P_ACT, 2'b01, 13'h0002);
    cmd(P_ACT, 2'b10, 13'h0003);
    chk("R14 accumulate", violSticky, 8'h0A);
    chk("R14 latest code", violCode, 4);
    chk("R14 latest bank", violBank, 2);
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    tReset();
    tDecode();
    tActPre();
    tIllegal();
    tRcd();
    tRpRc();
    tRrd();
    tRas();
    tMrd();
    tAutoPre();
    tEmrs();
    tSticky();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule